// File: doc/BRIEF.md
# Word-Wide Register Chain Bit-Flip Injector

This block holds the state flip-flops of a small target circuit, grouped into words of `WORD_W` bits, and lets a host inject single-event-upset style faults into them. In normal mode each word advances through the target's next-state logic whenever the functional clock enable is high. A start command switches every word's input multiplexer to its chain neighbour. The block then runs a read pass that sends the whole state to the host one word per clock. After that, a write pass takes back one host word per valid strobe. Between the two passes the host inverts whichever bits it wants to corrupt, one or many. Because a whole word moves per step, an injection needs only two passes of ceil(NUM_FF/WORD_W) transfers.

The read pass rotates the chain: the word leaving the tail re-enters at the head. After a full pass the state therefore sits exactly where it started, and the host may abandon the injection before writing anything. The target logic here is a placeholder. Word i increments by i+1 per enabled cycle. When NUM_FF is not a multiple of WORD_W, the upper bits of the top word are unused pad and are held at zero.

Top module: `rcfi_top`

## Requirements
- R1: During and after reset, `state_o` is all zero and `shift_mode_o`, `rd_valid_o` and `done_o` are low.
- R2: In normal mode with `func_en_i` high, every clock adds i+1 to word i (word i is `state_o` bits [i*WORD_W +: WORD_W]). The top word keeps only its NUM_FF-(NW-1)*WORD_W valid bits, with pad bits zero.
- R3: In normal mode with `func_en_i` low, `state_o` holds its value.
- R4: `start_i` in normal mode makes `shift_mode_o` rise on the next clock. `rd_valid_o` is then high for exactly NW consecutive cycles, and `rd_word_o` shows the words from index NW-1 down to index 0.
- R5: While `shift_mode_o` is high, the functional logic never advances, whatever the value of `func_en_i`.
- R6: When the read pass ends, `state_o` equals its value in the first read cycle.
- R7: In the write pass, each cycle with `wr_valid_i` high takes one word, and cycles without it stall. Words are written in the order they were read, so the first word written becomes word NW-1.
- R8: Pad bits in the first word written are discarded.
- R9: `done_o` is high for exactly one cycle, the one after the final word is taken. In that cycle `shift_mode_o` is already low.
- R10: `abort_i` before any word of the write pass returns the block to normal mode with the state unchanged. Once a word has been written, `abort_i` is ignored.
- R11: `start_i` while in shift mode and `wr_valid_i` while in normal mode have no effect.
- R12: After a write pass, each word equals the word read from it with the host's chosen bits inverted, whether one bit or several bits were flipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| func_en_i | input | 1 | Functional clock enable of the target |
| start_i | input | 1 | Begin an injection (normal mode only) |
| abort_i | input | 1 | Leave the write pass before its first word |
| wr_valid_i | input | 1 | Host word present on `wr_word_i` |
| wr_word_i | input | WORD_W | Word written back into the chain |
| rd_valid_o | output | 1 | Read-pass word present on `rd_word_o` |
| rd_word_o | output | WORD_W | Chain tail word |
| shift_mode_o | output | 1 | Chain is in shift mode |
| done_o | output | 1 | One-cycle pulse after the write pass ends |
| state_o | output | NUM_FF | Target flip-flop state |

## Verification
Several properties are checked on every cycle. The done pulse is one cycle long and coincides with the exit from shift mode. Read words appear only in shift mode, and a start in normal mode always opens a read pass. With the enable low in normal mode the state is held, and the state at the end of each read pass matches the state at its beginning. The word ordering, the discarding of pad bits, stalled and aborted write passes, and the bit-exact result of single-bit and multi-bit flips can only be shown by the bench scenarios, which compare against a behavioural model on every clock.

// File: rtl/rcfi_pkg.sv
package rcfi_pkg;
   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2
   } rcfi_phase_e;
endpackage

// File: rtl/rcfi_stage.sv
module rcfi_stage #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en_i,
   input  logic         func_sel_i,
   input  logic [W-1:0] func_d_i,
   input  logic [W-1:0] chain_d_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o <= '0;
      end else if (en_i) begin
         q_o <= func_sel_i ? func_d_i : chain_d_i;
      end
   end
endmodule

// File: rtl/rcfi_target_next.sv
module rcfi_target_next #(
   parameter int W   = 32,
   parameter int NW  = 4,
   parameter int REM = 32
) (
   input  logic [W-1:0] cur_i [NW],
   output logic [W-1:0] nxt_o [NW]
);
   localparam logic [W-1:0] LAST_MASK = {W{1'b1}} >> (W - REM);

   for (genvar i = 0; i < NW; i++) begin : g_word
      if (i == NW - 1 && REM != W) begin : g_pad
         assign nxt_o[i] = (cur_i[i] + W'(i + 1)) & LAST_MASK;
      end else begin : g_full
         assign nxt_o[i] = cur_i[i] + W'(i + 1);
      end
   end
endmodule

// File: rtl/rcfi_ctrl.sv
module rcfi_ctrl
   import rcfi_pkg::*;
#(
   parameter int NW = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        func_en_i,
   input  logic        start_i,
   input  logic        abort_i,
   input  logic        wr_valid_i,
   output rcfi_phase_e phase_o,
   output logic        stage_en_o,
   output logic        func_sel_o,
   output logic        first_wr_o,
   output logic        done_o
);
   localparam int CW = (NW > 1) ? $clog2(NW) : 1;
   localparam logic [CW-1:0] LASTC = CW'(NW - 1);

   rcfi_phase_e   phase;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= ST_RUN;
         cnt    <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         case (phase)
            ST_RUN: begin
               if (start_i) begin
                  phase <= ST_READ;
                  cnt   <= '0;
               end
            end
            ST_READ: begin
               if (cnt == LASTC) begin
                  phase <= ST_WRITE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_WRITE: begin
               if (wr_valid_i) begin
                  if (cnt == LASTC) begin
                     phase  <= ST_RUN;
                     cnt    <= '0;
                     done_o <= 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end else if (abort_i && cnt == '0) begin
                  phase <= ST_RUN;
               end
            end
            default: phase <= ST_RUN;
         endcase
      end
   end

   assign phase_o    = phase;
   assign func_sel_o = (phase == ST_RUN);
   assign first_wr_o = (phase == ST_WRITE) && (cnt == '0);
   always_comb begin
      case (phase)
         ST_RUN:  stage_en_o = func_en_i;
         ST_READ: stage_en_o = 1'b1;
         default: stage_en_o = wr_valid_i;
      endcase
   end
endmodule

// File: rtl/rcfi_top.sv
module rcfi_top
   import rcfi_pkg::*;
#(
   parameter int NUM_FF = 100,
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              func_en_i,
   input  logic              start_i,
   input  logic              abort_i,
   input  logic              wr_valid_i,
   input  logic [WORD_W-1:0] wr_word_i,
   output logic              rd_valid_o,
   output logic [WORD_W-1:0] rd_word_o,
   output logic              shift_mode_o,
   output logic              done_o,
   output logic [NUM_FF-1:0] state_o
);
   localparam int NW  = (NUM_FF + WORD_W - 1) / WORD_W;
   localparam int REM = NUM_FF - (NW - 1) * WORD_W;
   localparam logic [WORD_W-1:0] LAST_MASK = {WORD_W{1'b1}} >> (WORD_W - REM);

   if (WORD_W < 1 || NUM_FF < 1) begin : g_param_bad
      $error("rcfi_top: NUM_FF and WORD_W must be positive");
   end

   rcfi_phase_e       phase;
   logic              stage_en, func_sel, first_wr;
   logic [WORD_W-1:0] q   [NW];
   logic [WORD_W-1:0] nxt [NW];
   logic [WORD_W-1:0] wr_fix;
   logic [NW*WORD_W-1:0] flat;

   rcfi_ctrl #(.NW(NW)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .func_en_i  (func_en_i),
      .start_i    (start_i),
      .abort_i    (abort_i),
      .wr_valid_i (wr_valid_i),
      .phase_o    (phase),
      .stage_en_o (stage_en),
      .func_sel_o (func_sel),
      .first_wr_o (first_wr),
      .done_o     (done_o)
   );

   rcfi_target_next #(.W(WORD_W), .NW(NW), .REM(REM)) u_next (
      .cur_i (q),
      .nxt_o (nxt)
   );

   // first word written lands in the top word: strip its pad bits
   if (REM == WORD_W) begin : g_nopad
      assign wr_fix = wr_word_i;
      logic unused_first;
      assign unused_first = first_wr;
   end else begin : g_pad
      assign wr_fix = first_wr ? (wr_word_i & LAST_MASK) : wr_word_i;
   end

   for (genvar i = 0; i < NW; i++) begin : g_st
      logic [WORD_W-1:0] link;
      if (i == 0) begin : g_head
         assign link = (phase == ST_WRITE) ? wr_fix : q[NW-1];
      end else begin : g_body
         assign link = q[i-1];
      end
      rcfi_stage #(.W(WORD_W)) u_stage (
         .clk        (clk),
         .rst_n      (rst_n),
         .en_i       (stage_en),
         .func_sel_i (func_sel),
         .func_d_i   (nxt[i]),
         .chain_d_i  (link),
         .q_o        (q[i])
      );
      assign flat[i*WORD_W +: WORD_W] = q[i];
   end

   assign state_o      = flat[NUM_FF-1:0];
   assign rd_word_o    = q[NW-1];
   assign rd_valid_o   = (phase == ST_READ);
   assign shift_mode_o = (phase != ST_RUN);
endmodule

// File: rtl/rcfi_chk.sv
module rcfi_chk #(
   parameter int NUM_FF = 100
) (
   input logic              clk,
   input logic              rst_n,
   input logic              func_en_i,
   input logic              start_i,
   input logic              rd_valid_o,
   input logic              shift_mode_o,
   input logic              done_o,
   input logic [NUM_FF-1:0] state_o
);
   logic              rd_q;
   logic [NUM_FF-1:0] snap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= 1'b0;
         snap <= '0;
      end else begin
         rd_q <= rd_valid_o;
         if (rd_valid_o && !rd_q) snap <= state_o;
      end
   end

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R9
   done_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!shift_mode_o && $past(shift_mode_o)));
   // R4
   rd_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |-> shift_mode_o);
   // R4
   start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_mode_o && start_i) |=> rd_valid_o);
   // R3
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_mode_o && !func_en_i) |=> $stable(state_o));
   // R6
   rot_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_q && !rd_valid_o) |-> (state_o == snap));
endmodule

bind rcfi_top rcfi_chk #(.NUM_FF(NUM_FF)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .func_en_i    (func_en_i),
   .start_i      (start_i),
   .rd_valid_o   (rd_valid_o),
   .shift_mode_o (shift_mode_o),
   .done_o       (done_o),
   .state_o      (state_o)
);

// File: tb/sim_rcfi_top.sv
module sim_rcfi_top;
   localparam int CLK_PERIOD = 10;
   localparam int NFF  = 100;
   localparam int W    = 32;
   localparam int NW   = (NFF + W - 1) / W;
   localparam int REM  = NFF - (NW - 1) * W;
   localparam logic [W-1:0] LMASK = {W{1'b1}} >> (W - REM);

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           func_en_i = 1'b0, start_i = 1'b0, abort_i = 1'b0, wr_valid_i = 1'b0;
   logic [W-1:0]   wr_word_i = '0;
   logic           rd_valid_o, shift_mode_o, done_o;
   logic [W-1:0]   rd_word_o;
   logic [NFF-1:0] state_o;

   rcfi_top #(.NUM_FF(NFF), .WORD_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .func_en_i(func_en_i), .start_i(start_i),
      .abort_i(abort_i), .wr_valid_i(wr_valid_i), .wr_word_i(wr_word_i),
      .rd_valid_o(rd_valid_o), .rd_word_o(rd_word_o), .shift_mode_o(shift_mode_o),
      .done_o(done_o), .state_o(state_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int    total = 0, bad = 0;
   bit    finished = 1'b0;
   string cur_req = "R1";

   // behavioural reference model
   logic [W-1:0] mw [NW];
   int           mph = 0, mcnt = 0;
   bit           mdone = 1'b0;
   logic [W-1:0] rdq [$];

   task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic shift_in(input logic [W-1:0] v);
      for (int i = NW - 1; i > 0; i--) mw[i] = mw[i-1];
      mw[0] = v;
   endtask

   task automatic model_edge();
      mdone = 1'b0;
      case (mph)
         0: begin
            if (func_en_i) begin
               for (int i = 0; i < NW; i++) mw[i] = mw[i] + W'(i + 1);
               mw[NW-1] = mw[NW-1] & LMASK;
            end
            if (start_i) begin mph = 1; mcnt = 0; end
         end
         1: begin
            shift_in(mw[NW-1]);
            if (mcnt == NW - 1) begin mph = 2; mcnt = 0; end
            else mcnt++;
         end
         default: begin
            if (wr_valid_i) begin
               shift_in((mcnt == 0) ? (wr_word_i & LMASK) : wr_word_i);
               if (mcnt == NW - 1) begin mph = 0; mcnt = 0; mdone = 1'b1; end
               else mcnt++;
            end else if (abort_i && mcnt == 0) begin
               mph = 0;
            end
         end
      endcase
   endtask

   function automatic logic [NFF-1:0] model_state();
      logic [NW*W-1:0] f;
      for (int i = 0; i < NW; i++) f[i*W +: W] = mw[i];
      return f[NFF-1:0];
   endfunction

   task automatic compare();
      logic [255:0] e, a;
      e = {(mph != 0), (mph == 1), mdone, (mph == 1) ? mw[NW-1] : {W{1'b0}}, model_state()};
      a = {shift_mode_o, rd_valid_o, done_o, rd_valid_o ? rd_word_o : {W{1'b0}}, state_o};
      chk({cur_req, " cycle"}, a, e);
   endtask

   task automatic step();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare();
      if (rd_valid_o) rdq.push_back(rd_word_o);
   endtask

   task automatic read_pass();
      rdq.delete();
      start_i = 1'b1;
      step();
      start_i = 1'b0;
      repeat (NW) step();
   endtask

   task automatic put_word(input logic [W-1:0] v, input int stall);
      wr_valid_i = 1'b1;
      wr_word_i  = v;
      step();
      wr_valid_i = 1'b0;
      wr_word_i  = '0;
      repeat (stall) step();
   endtask

   function automatic logic [W-1:0] st_word(input int i);
      logic [NW*W-1:0] f;
      f = '0;
      f[NFF-1:0] = state_o;
      return f[i*W +: W];
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL %s watchdog: actual=hung expected=finished", cur_req);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [NFF-1:0] snap;
      logic [W-1:0]   flip [NW];
      logic [NW*W-1:0] ef;
      for (int i = 0; i < NW; i++) mw[i] = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", {shift_mode_o, rd_valid_o, done_o, state_o}, '0);
      rst_n = 1'b1;
      step();
      chk("R1", {shift_mode_o, rd_valid_o, done_o, state_o}, '0);

      // R2 functional stepping, pad bits held zero
      cur_req = "R2";
      func_en_i = 1'b1;
      repeat (5) step();
      chk("R2", st_word(1), 32'd10);
      chk("R2", st_word(NW-1), 32'd20 & LMASK);

      // R3 hold with enable low
      cur_req = "R3";
      func_en_i = 1'b0;
      repeat (3) step();
      chk("R3", st_word(0), 32'd5);

      // R4 R5 R6 read pass with enable held high
      cur_req = "R4";
      func_en_i = 1'b1;
      rdq.delete();
      start_i = 1'b1;
      step();
      start_i = 1'b0;
      snap = state_o;
      chk("R4", rd_valid_o, 1'b1);
      repeat (NW) step();
      chk("R4", rdq.size(), NW);
      chk("R4", rdq[0], 32'd24 & LMASK);
      chk("R4", rdq[NW-1], 32'd6);
      chk("R6", state_o, snap);
      cur_req = "R5";
      repeat (3) step();
      chk("R5", state_o, snap);
      chk("R5", shift_mode_o, 1'b1);

      // R7 R8 R9 R12 write pass with stalls and multi-bit flips
      cur_req = "R7";
      func_en_i = 1'b0;
      flip[0] = 32'h0010_0001;
      flip[1] = 32'h0000_0020;
      flip[2] = 32'h8000_0006;
      flip[3] = 32'h0000_0000;
      for (int j = 0; j < NW; j++) put_word(rdq[j] ^ flip[j], (j == NW - 1) ? 0 : 2);
      chk("R9", {done_o, shift_mode_o}, 2'b10);
      ef = '0;
      for (int j = 0; j < NW; j++) ef[(NW-1-j)*W +: W] = rdq[j] ^ flip[j];
      ef[(NW-1)*W +: W] = ef[(NW-1)*W +: W] & LMASK;
      chk("R12", state_o, ef[NFF-1:0]);
      chk("R8", st_word(NW-1), (32'd8 ^ 32'd1));
      cur_req = "R9";
      step();
      chk("R9", done_o, 1'b0);

      // R10 abort before first word
      cur_req = "R10";
      snap = state_o;
      read_pass();
      abort_i = 1'b1;
      step();
      abort_i = 1'b0;
      chk("R10", shift_mode_o, 1'b0);
      chk("R10", state_o, snap);

      // R10 abort after a word is ignored; R11 start in shift mode ignored
      read_pass();
      put_word(rdq[0], 0);
      abort_i = 1'b1;
      step();
      abort_i = 1'b0;
      chk("R10", shift_mode_o, 1'b1);
      cur_req = "R11";
      start_i = 1'b1;
      step();
      start_i = 1'b0;
      chk("R11", {shift_mode_o, rd_valid_o}, 2'b10);
      for (int j = 1; j < NW; j++) put_word(rdq[j], 0);
      chk("R12", state_o, snap);

      // R11 write strobe in normal mode
      step();
      wr_valid_i = 1'b1;
      wr_word_i  = 32'hFFFF_FFFF;
      step();
      wr_valid_i = 1'b0;
      chk("R11", state_o, snap);
      chk("R11", shift_mode_o, 1'b0);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule